// File: doc/BRIEF.md
# Unified data-space access unit

This unit turns one linear data address into an access on one of four target ports. The four targets are the general-purpose register file, the standard I/O space, the extended I/O space and internal SRAM. A requester supplies a 16-bit pointer value, an addressing mode, an optional 6-bit displacement, a read/write flag and write data. The unit computes the effective address and decodes its region in a first cycle. In the second cycle it drives the selected port with a region-local offset and returns read data together with a one-cycle done pulse.

The region boundaries are fixed by parameters. With the defaults they sit at 32, 96, 256 and 1280. Addresses from 1280 upward reach nothing: reads return zero, writes are dropped, and an error flag pulses alongside done. Every access takes the same two cycles, whatever its region. While an access is in flight, ready is low and no new request is taken.

The four addressing modes are plain, displaced, post-increment and pre-decrement. The unit also reports the updated pointer, so the requester can write it back to whichever pointer register it used.

Top module: `dspace_unit`

## Requirements
- R1: Effective addresses 0..31 select the register-file port, with `rf_addr` equal to the address.
- R2: Effective addresses 32..95 select the standard I/O port, with `io_addr` equal to the address minus 32.
- R3: Effective addresses 96..255 select the extended I/O port, with `xio_addr` equal to the address minus 96.
- R4: Effective addresses 256..1279 select the SRAM port, with `sram_addr` equal to the address minus 256.
- R5: For an effective address of 1280 or above, `err` is 1 in the done cycle, no port strobe is raised and `rd_data` is 0x00.
- R6: A request is taken at a rising edge where `req_valid` and `ready` are both 1. `done` and the port strobes are then high for exactly the following cycle, and `done` is low in the cycle the request is presented.
- R7: `ready` is 0 during the done cycle. A request held at that edge is not taken, so `done` is 0 in the cycle after.
- R8: In the done cycle of a read, `rd_data` equals the read data of the selected port. For a write it is 0x00.
- R9: Mode 2'b00 (plain) uses the pointer as the address. Mode 2'b01 (displaced) uses the pointer plus the zero-extended displacement, wrapping at 16 bits. In both modes `ptr_next` equals the pointer.
- R10: Mode 2'b10 (post-increment) uses the pointer and gives `ptr_next` = pointer+1. Mode 2'b11 (pre-decrement) uses pointer-1 for both the address and `ptr_next`. Both wrap at 16 bits, and `ptr_next` is valid in the done cycle.
- R11: At most one of the eight port strobes (`*_we`, `*_re`) is high at a time, and only in the done cycle. A write raises the selected region's `_we` with `port_wdata` equal to the request's write data. A read raises its `_re`.
- R12: In the cycle after reset is released, `ready` is 1 and `done`, `err` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Addressing mode (00 plain, 01 displaced, 10 post-inc, 11 pre-dec) |
| req_ptr | input | 16 | Pointer value |
| req_disp | input | 6 | Displacement for mode 01 |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Unit can take a request |
| done | output | 1 | Access cycle pulse |
| err | output | 1 | Address outside the decoded space |
| rd_data | output | 8 | Read result, valid with done |
| ptr_next | output | 16 | Updated pointer, valid with done |
| port_wdata | output | 8 | Write data shared by all ports |
| rf_addr | output | 5 | Register-file offset |
| rf_we | output | 1 | Register-file write strobe |
| rf_re | output | 1 | Register-file read strobe |
| rf_rdata | input | 8 | Register-file read data |
| io_addr | output | 6 | Standard I/O offset |
| io_we | output | 1 | Standard I/O write strobe |
| io_re | output | 1 | Standard I/O read strobe |
| io_rdata | input | 8 | Standard I/O read data |
| xio_addr | output | 8 | Extended I/O offset |
| xio_we | output | 1 | Extended I/O write strobe |
| xio_re | output | 1 | Extended I/O read strobe |
| xio_rdata | input | 8 | Extended I/O read data |
| sram_addr | output | 10 | SRAM offset |
| sram_we | output | 1 | SRAM write strobe |
| sram_re | output | 1 | SRAM read strobe |
| sram_rdata | input | 8 | SRAM read data |

## Verification
Reads are aimed at the first and last address of every region and at the first address past the decoded space. These cases separate an off-by-one in any boundary comparison from a wrong base subtraction in the offset.

Writes into each region followed by read-backs show that data and strobe reach the port the address selects and no other. Out-of-range writes show that nothing is strobed.

The four addressing modes are driven with pointers chosen so that the displaced, incremented and decremented addresses land in a different region than the raw pointer, or wrap at 16 bits. A mode mix-up or a missed wrap therefore shows up as a wrong port.

A request held high through the access cycle tells a correct hold-off apart from one that accepts back-to-back.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

    localparam int DATA_W = 8;
    localparam int PTR_W  = 16;

    typedef enum logic [1:0] {
        AM_PLAIN   = 2'b00,
        AM_DISP    = 2'b01,
        AM_POSTINC = 2'b10,
        AM_PREDEC  = 2'b11
    } amode_e;

    typedef enum logic [2:0] {
        RG_RF   = 3'd0,
        RG_IO   = 3'd1,
        RG_XIO  = 3'd2,
        RG_SRAM = 3'd3,
        RG_NONE = 3'd4
    } region_e;

    // True when addr lies in [base, base+size).
    function automatic logic in_window(input logic [31:0] addr,
                                       input int unsigned base,
                                       input int unsigned size);
        return (addr >= base) && (addr < base + size);
    endfunction

endpackage

// File: rtl/dspace_agen.sv
module dspace_agen
    import dspace_pkg::*;
#(
    parameter int DISP_W = 6
) (
    input  amode_e             mode,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [DISP_W-1:0]  disp,
    output logic [PTR_W-1:0]   ea,
    output logic [PTR_W-1:0]   ptr_upd
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0] disp_ext;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;

    assign disp_ext = PTR_W'(disp);
    assign ptr_inc  = ptr + ONE;
    assign ptr_dec  = ptr - ONE;

    always_comb begin
        ea      = ptr;
        ptr_upd = ptr;
        unique case (mode)
            AM_PLAIN:   begin ea = ptr;            ptr_upd = ptr;     end
            AM_DISP:    begin ea = ptr + disp_ext; ptr_upd = ptr;     end
            AM_POSTINC: begin ea = ptr;            ptr_upd = ptr_inc; end
            AM_PREDEC:  begin ea = ptr_dec;        ptr_upd = ptr_dec; end
            default:    begin ea = ptr;            ptr_upd = ptr;     end
        endcase
    end
endmodule

// File: rtl/dspace_decode.sv
module dspace_decode
    import dspace_pkg::*;
#(
    parameter int RF_N   = 32,
    parameter int IO_N   = 64,
    parameter int XIO_N  = 160,
    parameter int SRAM_N = 1024,
    parameter int OFF_W  = 10
) (
    input  logic [PTR_W-1:0] ea,
    output region_e          region,
    output logic [OFF_W-1:0] offset
);
    localparam int unsigned RF_BASE   = 0;
    localparam int unsigned IO_BASE   = RF_BASE + RF_N;
    localparam int unsigned XIO_BASE  = IO_BASE + IO_N;
    localparam int unsigned SRAM_BASE = XIO_BASE + XIO_N;

    logic [31:0] a32;
    assign a32 = 32'(ea);

    always_comb begin
        region = RG_NONE;
        offset = '0;
        if (in_window(a32, RF_BASE, RF_N)) begin
            region = RG_RF;
            offset = OFF_W'(a32 - RF_BASE);
        end else if (in_window(a32, IO_BASE, IO_N)) begin
            region = RG_IO;
            offset = OFF_W'(a32 - IO_BASE);
        end else if (in_window(a32, XIO_BASE, XIO_N)) begin
            region = RG_XIO;
            offset = OFF_W'(a32 - XIO_BASE);
        end else if (in_window(a32, SRAM_BASE, SRAM_N)) begin
            region = RG_SRAM;
            offset = OFF_W'(a32 - SRAM_BASE);
        end
    end
endmodule

// File: rtl/dspace_route.sv
module dspace_route
    import dspace_pkg::*;
#(
    parameter int OFF_W   = 10,
    parameter int RF_AW   = 5,
    parameter int IO_AW   = 6,
    parameter int XIO_AW  = 8,
    parameter int SRAM_AW = 10
) (
    input  logic              active,
    input  region_e           region,
    input  logic [OFF_W-1:0]  offset,
    input  logic              write,
    output logic [RF_AW-1:0]   rf_addr,
    output logic               rf_we,
    output logic               rf_re,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic [IO_AW-1:0]   io_addr,
    output logic               io_we,
    output logic               io_re,
    input  logic [DATA_W-1:0]  io_rdata,
    output logic [XIO_AW-1:0]  xio_addr,
    output logic               xio_we,
    output logic               xio_re,
    input  logic [DATA_W-1:0]  xio_rdata,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               sram_we,
    output logic               sram_re,
    input  logic [DATA_W-1:0]  sram_rdata,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int NREG = 4;

    logic [NREG-1:0] sel;
    logic [NREG-1:0] we_v;
    logic [NREG-1:0] re_v;

    // One select line per addressable region.
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g]  = active && (region == region_e'(g));
        assign we_v[g] = sel[g] && write;
        assign re_v[g] = sel[g] && !write;
    end

    assign rf_we   = we_v[RG_RF];
    assign rf_re   = re_v[RG_RF];
    assign io_we   = we_v[RG_IO];
    assign io_re   = re_v[RG_IO];
    assign xio_we  = we_v[RG_XIO];
    assign xio_re  = re_v[RG_XIO];
    assign sram_we = we_v[RG_SRAM];
    assign sram_re = re_v[RG_SRAM];

    // Offsets reach only the selected port; the others sit at zero.
    assign rf_addr   = sel[RG_RF]   ? RF_AW'(offset)   : '0;
    assign io_addr   = sel[RG_IO]   ? IO_AW'(offset)   : '0;
    assign xio_addr  = sel[RG_XIO]  ? XIO_AW'(offset)  : '0;
    assign sram_addr = sel[RG_SRAM] ? SRAM_AW'(offset) : '0;

    always_comb begin
        rd_data = '0;
        if (active && !write) begin
            unique case (region)
                RG_RF:   rd_data = rf_rdata;
                RG_IO:   rd_data = io_rdata;
                RG_XIO:  rd_data = xio_rdata;
                RG_SRAM: rd_data = sram_rdata;
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/dspace_unit.sv
module dspace_unit
    import dspace_pkg::*;
#(
    parameter int RF_N   = 32,
    parameter int IO_N   = 64,
    parameter int XIO_N  = 160,
    parameter int SRAM_N = 1024,
    parameter int DISP_W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic [1:0]   req_mode,
    input  logic [15:0]  req_ptr,
    input  logic [5:0]   req_disp,
    input  logic [7:0]   req_wdata,
    output logic         ready,
    output logic         done,
    output logic         err,
    output logic [7:0]   rd_data,
    output logic [15:0]  ptr_next,
    output logic [7:0]   port_wdata,
    output logic [4:0]   rf_addr,
    output logic         rf_we,
    output logic         rf_re,
    input  logic [7:0]   rf_rdata,
    output logic [5:0]   io_addr,
    output logic         io_we,
    output logic         io_re,
    input  logic [7:0]   io_rdata,
    output logic [7:0]   xio_addr,
    output logic         xio_we,
    output logic         xio_re,
    input  logic [7:0]   xio_rdata,
    output logic [9:0]   sram_addr,
    output logic         sram_we,
    output logic         sram_re,
    input  logic [7:0]   sram_rdata
);
    localparam int RF_AW   = $clog2(RF_N);
    localparam int IO_AW   = $clog2(IO_N);
    localparam int XIO_AW  = $clog2(XIO_N);
    localparam int SRAM_AW = $clog2(SRAM_N);
    // The SRAM window is the widest region, so its offset width covers all.
    localparam int OFF_W   = SRAM_AW;

    typedef struct packed {
        region_e             region;
        logic [OFF_W-1:0]    offset;
        logic                write;
        logic [DATA_W-1:0]   wdata;
        logic [PTR_W-1:0]    ptr_upd;
    } stage_t;

    logic [PTR_W-1:0] ea_c;
    logic [PTR_W-1:0] ptr_upd_c;
    region_e          region_c;
    logic [OFF_W-1:0] offset_c;
    logic             busy_q;
    stage_t           st_q;
    logic             accept;

    // First cycle: effective address and region decode.
    dspace_agen #(.DISP_W(DISP_W)) u_agen (
        .mode    (amode_e'(req_mode)),
        .ptr     (req_ptr),
        .disp    (req_disp),
        .ea      (ea_c),
        .ptr_upd (ptr_upd_c)
    );

    dspace_decode #(
        .RF_N(RF_N), .IO_N(IO_N), .XIO_N(XIO_N), .SRAM_N(SRAM_N), .OFF_W(OFF_W)
    ) u_dec (
        .ea     (ea_c),
        .region (region_c),
        .offset (offset_c)
    );

    assign ready  = !busy_q;
    assign accept = req_valid && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            st_q   <= '{region: RG_NONE, default: '0};
        end else begin
            busy_q <= accept;
            if (accept) begin
                st_q.region  <= region_c;
                st_q.offset  <= offset_c;
                st_q.write   <= req_write;
                st_q.wdata   <= req_wdata;
                st_q.ptr_upd <= ptr_upd_c;
            end
        end
    end

    // Second cycle: drive the selected port and return data.
    dspace_route #(
        .OFF_W(OFF_W), .RF_AW(RF_AW), .IO_AW(IO_AW),
        .XIO_AW(XIO_AW), .SRAM_AW(SRAM_AW)
    ) u_route (
        .active     (busy_q),
        .region     (st_q.region),
        .offset     (st_q.offset),
        .write      (st_q.write),
        .rf_addr    (rf_addr),
        .rf_we      (rf_we),
        .rf_re      (rf_re),
        .rf_rdata   (rf_rdata),
        .io_addr    (io_addr),
        .io_we      (io_we),
        .io_re      (io_re),
        .io_rdata   (io_rdata),
        .xio_addr   (xio_addr),
        .xio_we     (xio_we),
        .xio_re     (xio_re),
        .xio_rdata  (xio_rdata),
        .sram_addr  (sram_addr),
        .sram_we    (sram_we),
        .sram_re    (sram_re),
        .sram_rdata (sram_rdata),
        .rd_data    (rd_data)
    );

    assign done       = busy_q;
    assign err        = busy_q && (st_q.region == RG_NONE);
    assign ptr_next   = st_q.ptr_upd;
    assign port_wdata = st_q.wdata;
endmodule

// File: rtl/dspace_unit_chk.sv
module dspace_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_mode,
    input logic [15:0] req_ptr,
    input logic        ready,
    input logic        done,
    input logic        err,
    input logic [7:0]  rd_data,
    input logic [15:0] ptr_next,
    input logic        rf_we,
    input logic        rf_re,
    input logic        io_we,
    input logic        io_re,
    input logic        xio_we,
    input logic        xio_re,
    input logic        sram_we,
    input logic        sram_re
);
    logic [7:0] strobes;
    assign strobes = {rf_we, rf_re, io_we, io_re, xio_we, xio_re, sram_we, sram_re};

    assert_done_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> done);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_holds_off_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !ready);

    assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobes));

    assert_strobe_in_done_R11: assert property (@(posedge clk) disable iff (rst)
        (strobes != 8'h00) |-> done);

    assert_err_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        err |-> (strobes == 8'h00 && rd_data == 8'h00 && done));

    assert_postinc_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready && req_mode == 2'b10) |=> (ptr_next == $past(req_ptr) + 16'd1));

    assert_reset_idle_R12: assert property (@(posedge clk)
        rst |=> (ready && !done && !err));
endmodule

bind dspace_unit dspace_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_ptr   (req_ptr),
    .ready     (ready),
    .done      (done),
    .err       (err),
    .rd_data   (rd_data),
    .ptr_next  (ptr_next),
    .rf_we     (rf_we),
    .rf_re     (rf_re),
    .io_we     (io_we),
    .io_re     (io_re),
    .xio_we    (xio_we),
    .xio_re    (xio_re),
    .sram_we   (sram_we),
    .sram_re   (sram_re)
);

// File: tb/tb_dspace_unit.sv
module tb_dspace_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [15:0] req_ptr = '0;
    logic [5:0]  req_disp = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, done, err;
    logic [7:0]  rd_data, port_wdata;
    logic [15:0] ptr_next;
    logic [4:0]  rf_addr;
    logic [5:0]  io_addr;
    logic [7:0]  xio_addr;
    logic [9:0]  sram_addr;
    logic        rf_we, rf_re, io_we, io_re, xio_we, xio_re, sram_we, sram_re;
    logic [7:0]  rf_rdata, io_rdata, xio_rdata, sram_rdata;

    logic [7:0] rf_mem   [32];
    logic [7:0] io_mem   [64];
    logic [7:0] xio_mem  [160];
    logic [7:0] sram_mem [1024];

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    dspace_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mode(req_mode), .req_ptr(req_ptr), .req_disp(req_disp),
        .req_wdata(req_wdata), .ready(ready), .done(done), .err(err),
        .rd_data(rd_data), .ptr_next(ptr_next), .port_wdata(port_wdata),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_re(rf_re), .rf_rdata(rf_rdata),
        .io_addr(io_addr), .io_we(io_we), .io_re(io_re), .io_rdata(io_rdata),
        .xio_addr(xio_addr), .xio_we(xio_we), .xio_re(xio_re), .xio_rdata(xio_rdata),
        .sram_addr(sram_addr), .sram_we(sram_we), .sram_re(sram_re), .sram_rdata(sram_rdata)
    );

    // Port-side device models.
    assign rf_rdata   = rf_mem[rf_addr];
    assign io_rdata   = io_mem[io_addr];
    assign xio_rdata  = (xio_addr < 8'd160) ? xio_mem[xio_addr] : 8'h00;
    assign sram_rdata = sram_mem[sram_addr];

    always @(posedge clk) begin
        if (rf_we)   rf_mem[rf_addr]     <= port_wdata;
        if (io_we)   io_mem[io_addr]     <= port_wdata;
        if (xio_we && xio_addr < 8'd160) xio_mem[xio_addr] <= port_wdata;
        if (sram_we) sram_mem[sram_addr] <= port_wdata;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_ea(input logic [1:0] m, input logic [15:0] p,
                                           input logic [5:0] d);
        case (m)
            2'b01:   return p + {10'd0, d};
            2'b11:   return p - 16'd1;
            default: return p;
        endcase
    endfunction

    function automatic logic [15:0] exp_next(input logic [1:0] m, input logic [15:0] p);
        case (m)
            2'b10:   return p + 16'd1;
            2'b11:   return p - 16'd1;
            default: return p;
        endcase
    endfunction

    // One complete access with all port-side checks; returns read data seen.
    task automatic access(input string req, input logic [1:0] m, input logic [15:0] p,
                          input logic [5:0] d, input logic wr, input logic [7:0] wd,
                          output logic [7:0] got);
        logic [15:0] ea;
        logic [7:0]  exp_strobe;
        logic [7:0]  exp_rd;
        logic [31:0] exp_off;
        logic [31:0] act_off;
        logic        exp_err;
        ea = exp_ea(m, p, d);
        exp_err = 1'b0;
        exp_rd = 8'h00;
        exp_off = 0;
        act_off = 0;
        @(negedge clk);
        chk(req, "ready before request", {31'd0, ready}, 32'd1);
        chk(req, "done before accept", {31'd0, done}, 32'd0);
        req_valid = 1'b1; req_write = wr; req_mode = m;
        req_ptr = p; req_disp = d; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (ea < 16'd32) begin
            exp_strobe = wr ? 8'b1000_0000 : 8'b0100_0000;
            exp_off = {16'd0, ea}; act_off = {27'd0, rf_addr};
            exp_rd = rf_mem[ea[4:0]];
        end else if (ea < 16'd96) begin
            exp_strobe = wr ? 8'b0010_0000 : 8'b0001_0000;
            exp_off = {16'd0, ea} - 32'd32; act_off = {26'd0, io_addr};
            exp_rd = io_mem[exp_off[5:0]];
        end else if (ea < 16'd256) begin
            exp_strobe = wr ? 8'b0000_1000 : 8'b0000_0100;
            exp_off = {16'd0, ea} - 32'd96; act_off = {24'd0, xio_addr};
            exp_rd = xio_mem[exp_off[7:0]];
        end else if (ea < 16'd1280) begin
            exp_strobe = wr ? 8'b0000_0010 : 8'b0000_0001;
            exp_off = {16'd0, ea} - 32'd256; act_off = {22'd0, sram_addr};
            exp_rd = sram_mem[exp_off[9:0]];
        end else begin
            exp_strobe = 8'h00;
            exp_err = 1'b1;
        end
        if (wr || exp_err) exp_rd = 8'h00;
        chk(req, "done in access cycle", {31'd0, done}, 32'd1);
        chk(req, "ready low in access cycle", {31'd0, ready}, 32'd0);
        chk(req, "err", {31'd0, err}, {31'd0, exp_err});
        chk(req, "strobes", {24'd0, rf_we, rf_re, io_we, io_re, xio_we, xio_re, sram_we, sram_re},
            {24'd0, exp_strobe});
        chk(req, "port offset", act_off, exp_off);
        chk(req, "rd_data", {24'd0, rd_data}, {24'd0, exp_rd});
        chk(req, "ptr_next", {16'd0, ptr_next}, {16'd0, exp_next(m, p)});
        if (wr && !exp_err) chk(req, "port_wdata", {24'd0, port_wdata}, {24'd0, wd});
        got = rd_data;
        @(negedge clk);
        chk(req, "done single cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12", "ready", {31'd0, ready}, 32'd1);
        chk("R12", "done", {31'd0, done}, 32'd0);
        chk("R12", "err", {31'd0, err}, 32'd0);
        chk("R12", "strobes", {24'd0, rf_we, rf_re, io_we, io_re, xio_we, xio_re, sram_we, sram_re}, 32'd0);
    endtask

    task automatic t_bounds();
        logic [7:0] g;
        access("R1", 2'b00, 16'd0,    6'd0, 1'b0, 8'h00, g);
        access("R1", 2'b00, 16'd31,   6'd0, 1'b0, 8'h00, g);
        access("R2", 2'b00, 16'd32,   6'd0, 1'b0, 8'h00, g);
        access("R2", 2'b00, 16'd95,   6'd0, 1'b0, 8'h00, g);
        access("R3", 2'b00, 16'd96,   6'd0, 1'b0, 8'h00, g);
        access("R3", 2'b00, 16'd255,  6'd0, 1'b0, 8'h00, g);
        access("R4", 2'b00, 16'd256,  6'd0, 1'b0, 8'h00, g);
        access("R4", 2'b00, 16'd1279, 6'd0, 1'b0, 8'h00, g);
        access("R8", 2'b00, 16'd700,  6'd0, 1'b0, 8'h00, g);
        chk("R8", "sram read value", {24'd0, g}, {24'd0, 8'(700 - 256) * 8'd7 + 8'd3});
    endtask

    task automatic t_out_of_range();
        logic [7:0] g;
        access("R5", 2'b00, 16'd1280,   6'd0, 1'b0, 8'h00, g);
        chk("R5", "read above space", {24'd0, g}, 32'd0);
        access("R5", 2'b00, 16'hFFFF,   6'd0, 1'b0, 8'h00, g);
        access("R5", 2'b00, 16'd1280,   6'd0, 1'b1, 8'hA5, g);
        access("R5", 2'b00, 16'd4000,   6'd0, 1'b1, 8'h3C, g);
    endtask

    task automatic t_writes();
        logic [7:0] g;
        access("R11", 2'b00, 16'd7,    6'd0, 1'b1, 8'h91, g);
        access("R8",  2'b00, 16'd7,    6'd0, 1'b0, 8'h00, g);
        chk("R11", "rf readback", {24'd0, g}, 32'h91);
        access("R11", 2'b00, 16'd40,   6'd0, 1'b1, 8'h62, g);
        access("R8",  2'b00, 16'd40,   6'd0, 1'b0, 8'h00, g);
        chk("R11", "io readback", {24'd0, g}, 32'h62);
        access("R11", 2'b00, 16'd200,  6'd0, 1'b1, 8'hE4, g);
        access("R8",  2'b00, 16'd200,  6'd0, 1'b0, 8'h00, g);
        chk("R11", "xio readback", {24'd0, g}, 32'hE4);
        access("R11", 2'b00, 16'd1000, 6'd0, 1'b1, 8'h17, g);
        access("R8",  2'b00, 16'd1000, 6'd0, 1'b0, 8'h00, g);
        chk("R11", "sram readback", {24'd0, g}, 32'h17);
    endtask

    task automatic t_modes();
        logic [7:0] g;
        access("R9",  2'b01, 16'd250,    6'd10, 1'b0, 8'h00, g);
        access("R9",  2'b01, 16'hFFFF,   6'd1,  1'b0, 8'h00, g);
        access("R9",  2'b01, 16'd20,     6'd63, 1'b1, 8'h5E, g);
        access("R10", 2'b10, 16'd255,    6'd0,  1'b0, 8'h00, g);
        access("R10", 2'b10, 16'hFFFF,   6'd0,  1'b0, 8'h00, g);
        access("R10", 2'b11, 16'd33,     6'd9,  1'b0, 8'h00, g);
        access("R10", 2'b11, 16'd0,      6'd0,  1'b1, 8'hCC, g);
        access("R10", 2'b11, 16'd256,    6'd0,  1'b1, 8'h4D, g);
        access("R8",  2'b00, 16'd255,    6'd0,  1'b0, 8'h00, g);
        chk("R10", "pre-dec write landed at 255", {24'd0, g}, 32'h4D);
    endtask

    task automatic t_holdoff();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_mode = 2'b00; req_ptr = 16'd5;
        @(negedge clk);
        chk("R6", "done after accept", {31'd0, done}, 32'd1);
        chk("R7", "ready low while busy", {31'd0, ready}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7", "held request not taken", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk("R7", "no late access", {31'd0, done}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++)   rf_mem[i]   = 8'(i * 3 + 1);
        for (int i = 0; i < 64; i++)   io_mem[i]   = 8'(i) ^ 8'h5A;
        for (int i = 0; i < 160; i++)  xio_mem[i]  = 8'(i + 64);
        for (int i = 0; i < 1024; i++) sram_mem[i] = 8'(i) * 8'd7 + 8'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bounds();
        t_out_of_range();
        t_writes();
        t_modes();
        t_holdoff();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule